// File: doc/BRIEF.md
# Grouped-Frame SPI Master

A memory-mapped SPI master that takes transmit words from a register bus, queues them in a transmit FIFO and shifts them out MSB first in SPI mode 0. Each received frame is captured into a receive FIFO that software drains through the same bus. The frame width comes from a frame-size register. The serial clock is the system clock divided by 2×(divider+1).

Frames are sent in groups whose length is set by a frame-count field in the control register. A hold option keeps the single chip select low across the whole group. When hold is off, chip select is released after every frame. Transmit-done and receive-ready are reported only once the last frame of a group has finished, and the frame counter then reloads for the next group. These two events and a receive-overflow event are latched in a raw interrupt register. They are masked by enables in the control register and ORed onto one interrupt line.

The group controller has four states. GS_IDLE goes to GS_SHIFT (frame start) when the block is enabled, the transmit FIFO holds data and the frame counter is non-zero. GS_SHIFT leaves when the frame ends: to GS_FINISH if this was the last frame of the group, to GS_RELEASE (gap) if hold is off, or back to GS_IDLE if hold is on. GS_RELEASE and GS_FINISH both return to GS_IDLE. The shifter has three states: SH_IDLE, SH_LOW (serial clock low) and SH_HIGH (serial clock high). A soft reset forces both state machines to idle.

Top module: `spi_grp_master`

## Requirements
- R1: After reset the registers read as follows: control (word 0) reads 0x80000102, frame size (word 1) reads 4, clock divider (word 6) reads 7, status (word 2) reads 0x2440, raw interrupt (word 9) and masked interrupt (word 8) read 0, chip select is high and irq is low.
- R2: A frame shifts the low N bits of the transmit word, MSB first. N is frame-size bits 4:0, and 0 means 32. MOSI changes while SCLK is low and MISO is sampled on the SCLK rising edge. The received bits are placed right-aligned in the word read from receive data (word 4). Transmit data is written at word 5.
- R3: SCLK idles low, and one SCLK period lasts 2×(divider+1) system clocks.
- R4: A frame starts only when control bit 0 (enable) is set and the transmit FIFO is not empty. Words written while the block is disabled stay queued and produce no SCLK edges.
- R5: While control bit 26 (hold) is set, chip select stays low from the first frame of a group to its end and rises once. While bit 26 is clear, chip select rises after every frame.
- R6: The frame count is taken from control bits 23:8 on every control write. Status bits 0 (transmit done) and 1 (receive ready) clear at each frame start. They are set, together with raw bits 0 and 1, only after the counted frames are done, and the count then reloads. A count of 0 sends nothing.
- R7: A frame that ends with the receive FIFO full discards its data and sets status bit 2 and raw bit 2. A read of receive data clears status bit 2.
- R8: The masked interrupt is raw bit 2 gated by control bit 6, raw bit 1 gated by control bit 4, and raw bit 0 gated by control bit 5. irq is the OR of the masked bits. Writing 1s to interrupt clear (word 3) bits 0 to 2 clears the matching raw bits.
- R9: Writes to frame size are ignored while control bit 0 is set.
- R10: Writes to status, raw interrupt and masked interrupt leave their read values unchanged.
- R11: FIFO depth is 4 unless control bit 29 is set. With bit 29 set, the depth is 32 for frames of 8 bits or fewer, 16 for frames of 16 bits or fewer, and 8 otherwise. The depth is fixed at each control write. Status flags: receive full/near-full at bits 4/5, receive empty/near-empty at bits 6/7, transmit full/near-full at bits 8/9, transmit empty/near-empty at bits 10/11. Near-full means depth−1 words and near-empty means 1 word.
- R12: Writing control with bit 31 set returns every register, both FIFOs and both state machines to their reset state.
- R13: Status bit 14 is high while a frame is shifting. Bit 13 follows the chip-select level. Bit 12 is high from the first frame start of a group until the group finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The hardest situation to reach from the ports is a receive overflow. The receive FIFO has to fill through completed frames while software does not read it. The bench gets there by sending five single-frame groups through a loopback wire and never popping the receive FIFO, which leaves the fifth frame with nowhere to go. The half-finished hold-mode group is a second hard case. The bench queues only the first of three frames, then checks the chip-select level and the done flag while the group waits for the rest of its data.

// File: rtl/spi_grp_pkg.sv
package spi_grp_pkg;
    // register word indices
    localparam logic [3:0] RA_CTRL   = 4'd0;
    localparam logic [3:0] RA_FSIZE  = 4'd1;
    localparam logic [3:0] RA_STAT   = 4'd2;
    localparam logic [3:0] RA_ICLR   = 4'd3;
    localparam logic [3:0] RA_RXD    = 4'd4;
    localparam logic [3:0] RA_TXD    = 4'd5;
    localparam logic [3:0] RA_CLKDIV = 4'd6;
    localparam logic [3:0] RA_SSEL   = 4'd7;
    localparam logic [3:0] RA_MASKED = 4'd8;
    localparam logic [3:0] RA_RAW    = 4'd9;

    // control field positions
    localparam int CB_EN     = 0;
    localparam int CB_IE_RX  = 4;
    localparam int CB_IE_TX  = 5;
    localparam int CB_IE_OVF = 6;
    localparam int CB_HOLD   = 26;
    localparam int CB_BIG    = 29;
    localparam int CB_SRST   = 31;
    localparam int CNT_LO    = 8;
    localparam int CNT_HI    = 23;
    localparam int CNT_W     = CNT_HI - CNT_LO + 1;

    localparam logic [31:0] CTRL_RST = 32'h8000_0102;

    typedef enum logic [1:0] {GS_IDLE, GS_SHIFT, GS_RELEASE, GS_FINISH} grp_state_t;
    typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_state_t;
endpackage

// File: rtl/spi_grp_fifo.sv
module spi_grp_fifo #(
    parameter int DW        = 32,
    parameter int MAX_DEPTH = 32,
    localparam int AW       = $clog2(MAX_DEPTH),
    localparam int CW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    input  logic [CW-1:0] lim,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [DW-1:0] mem [MAX_DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign full    = (count >= lim);
    assign push_ok = push && !full;
    assign pop_ok  = pop && (count != '0);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/spi_grp_shift.sv
module spi_grp_shift
    import spi_grp_pkg::*;
#(
    parameter int DW     = 32,
    parameter int DIV_W  = 8,
    localparam int LEN_W = $clog2(DW) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic [DW-1:0]    tx_word,
    input  logic [LEN_W-1:0] len,
    input  logic [DIV_W-1:0] div,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rx_word
);
    sh_state_t        st, st_nxt;
    logic [DW-1:0]    sreg, rreg;
    logic [LEN_W-1:0] left;
    logic [DIV_W-1:0] tick;
    logic             tick_end;

    assign tick_end = (tick == div);
    assign mosi     = sreg[DW-1];
    assign busy     = (st != SH_IDLE);
    assign rx_word  = rreg;

    always_comb begin
        st_nxt = st;
        unique case (st)
            SH_IDLE: if (start)    st_nxt = SH_LOW;
            SH_LOW:  if (tick_end) st_nxt = SH_HIGH;
            SH_HIGH: if (tick_end) st_nxt = (left == LEN_W'(1)) ? SH_IDLE : SH_LOW;
            default: st_nxt = SH_IDLE;
        endcase
        if (abort) st_nxt = SH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SH_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            rreg <= '0;
            left <= '0;
            tick <= '0;
            sclk <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                tick <= '0;
                sclk <= 1'b0;
            end else begin
                unique case (st)
                    SH_IDLE: if (start) begin
                        sreg <= tx_word << (LEN_W'(DW) - len);
                        rreg <= '0;
                        left <= len;
                        tick <= '0;
                        sclk <= 1'b0;
                    end
                    SH_LOW: if (tick_end) begin
                        tick <= '0;
                        sclk <= 1'b1;
                        rreg <= {rreg[DW-2:0], miso};
                    end else begin
                        tick <= tick + 1'b1;
                    end
                    SH_HIGH: if (tick_end) begin
                        tick <= '0;
                        sclk <= 1'b0;
                        if (left == LEN_W'(1)) begin
                            done <= 1'b1;
                        end else begin
                            left <= left - 1'b1;
                            sreg <= {sreg[DW-2:0], 1'b0};
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_grp_master.sv
module spi_grp_master
    import spi_grp_pkg::*;
#(
    parameter int FIFO_MAX = 32,
    parameter int DIV_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);
    localparam int DW    = 32;
    localparam int FS_W  = $clog2(DW);
    localparam int LEN_W = FS_W + 1;
    localparam int CW    = $clog2(FIFO_MAX) + 1;

    // register state
    logic [31:0]      ctrl_q;
    logic [FS_W-1:0]  fsize_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       ssel_q;
    logic [CW-1:0]    depth_q;
    logic [2:0]       raw_q;
    logic             txdone_q, rxrdy_q, ovf_q, open_q, cs_n_q;
    logic [CNT_W-1:0] fcnt_q;
    grp_state_t       gst, gst_nxt;

    // bus decode
    logic wr, srst, wr_ctrl, tx_push, rx_pop;
    assign wr      = bus_en && bus_we;
    assign wr_ctrl = wr && (bus_addr == RA_CTRL);
    assign srst    = wr_ctrl && bus_wdata[CB_SRST];
    assign tx_push = wr && (bus_addr == RA_TXD);
    assign rx_pop  = bus_en && !bus_we && (bus_addr == RA_RXD);

    // fifos and shifter
    logic [DW-1:0]    tx_dout, rx_dout, sh_rx;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic             tx_full, rx_full;
    logic             start_go, sh_busy, sh_done, frame_end, ovf_evt, fin;
    logic [LEN_W-1:0] eff_len;

    assign eff_len   = (fsize_q == '0) ? LEN_W'(DW) : LEN_W'(fsize_q);
    assign start_go  = (gst == GS_IDLE) && ctrl_q[CB_EN] && (tx_cnt != '0)
                       && (fcnt_q != '0) && !srst;
    assign frame_end = (gst == GS_SHIFT) && sh_done;
    assign ovf_evt   = frame_end && rx_full;
    assign fin       = (gst == GS_FINISH);

    spi_grp_fifo #(.DW(DW), .MAX_DEPTH(FIFO_MAX)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(srst), .push(tx_push), .pop(start_go),
        .din(bus_wdata), .lim(depth_q), .dout(tx_dout), .count(tx_cnt), .full(tx_full)
    );

    spi_grp_fifo #(.DW(DW), .MAX_DEPTH(FIFO_MAX)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(srst), .push(frame_end), .pop(rx_pop),
        .din(sh_rx), .lim(depth_q), .dout(rx_dout), .count(rx_cnt), .full(rx_full)
    );

    spi_grp_shift #(.DW(DW), .DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .abort(srst), .start(start_go), .tx_word(tx_dout),
        .len(eff_len), .div(div_q), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .busy(sh_busy), .done(sh_done), .rx_word(sh_rx)
    );

    function automatic logic [CW-1:0] depth_sel(input logic big, input logic [FS_W-1:0] sz);
        logic [LEN_W-1:0] w;
        w = (sz == '0) ? LEN_W'(DW) : LEN_W'(sz);
        if (!big)                 return CW'(FIFO_MAX / 8);
        else if (w <= LEN_W'(8))  return CW'(FIFO_MAX);
        else if (w <= LEN_W'(16)) return CW'(FIFO_MAX / 2);
        else                      return CW'(FIFO_MAX / 4);
    endfunction

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            fsize_q <= FS_W'(4);
            div_q   <= DIV_W'(7);
            ssel_q  <= '0;
            depth_q <= CW'(FIFO_MAX / 8);
        end else if (srst) begin
            ctrl_q  <= CTRL_RST;
            fsize_q <= FS_W'(4);
            div_q   <= DIV_W'(7);
            ssel_q  <= '0;
            depth_q <= CW'(FIFO_MAX / 8);
        end else if (wr) begin
            unique case (bus_addr)
                RA_CTRL: begin
                    ctrl_q  <= bus_wdata;
                    depth_q <= depth_sel(bus_wdata[CB_BIG], fsize_q);
                end
                RA_FSIZE:  if (!ctrl_q[CB_EN]) fsize_q <= bus_wdata[FS_W-1:0];
                RA_CLKDIV: div_q  <= bus_wdata[DIV_W-1:0];
                RA_SSEL:   ssel_q <= bus_wdata[7:0];
                default: ;
            endcase
        end
    end

    // group state register
    always_comb begin
        gst_nxt = gst;
        unique case (gst)
            GS_IDLE:  if (start_go) gst_nxt = GS_SHIFT;
            GS_SHIFT: if (sh_done) begin
                if (fcnt_q == CNT_W'(1))  gst_nxt = GS_FINISH;
                else if (!ctrl_q[CB_HOLD]) gst_nxt = GS_RELEASE;
                else                       gst_nxt = GS_IDLE;
            end
            GS_RELEASE: gst_nxt = GS_IDLE;
            GS_FINISH:  gst_nxt = GS_IDLE;
            default:    gst_nxt = GS_IDLE;
        endcase
        if (srst) gst_nxt = GS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gst <= GS_IDLE;
        else        gst <= gst_nxt;
    end

    // group outputs
    logic [2:0] iclr_mask;
    assign iclr_mask = (wr && (bus_addr == RA_ICLR)) ? bus_wdata[2:0] : 3'b000;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1; fcnt_q <= CNT_W'(1); txdone_q <= 1'b0; rxrdy_q <= 1'b0;
            ovf_q  <= 1'b0; open_q <= 1'b0;      raw_q    <= '0;
        end else if (srst) begin
            cs_n_q <= 1'b1; fcnt_q <= CNT_W'(1); txdone_q <= 1'b0; rxrdy_q <= 1'b0;
            ovf_q  <= 1'b0; open_q <= 1'b0;      raw_q    <= '0;
        end else begin
            raw_q <= (raw_q & ~iclr_mask) | {ovf_evt, fin, fin};
            if (rx_pop) ovf_q <= 1'b0;
            if (start_go) begin
                cs_n_q   <= 1'b0;
                txdone_q <= 1'b0;
                rxrdy_q  <= 1'b0;
                open_q   <= 1'b1;
            end
            if (frame_end) begin
                fcnt_q <= fcnt_q - 1'b1;
                if (rx_full) ovf_q <= 1'b1;
                if (!ctrl_q[CB_HOLD]) cs_n_q <= 1'b1;
            end
            if (fin) begin
                fcnt_q   <= ctrl_q[CNT_HI:CNT_LO];
                cs_n_q   <= 1'b1;
                txdone_q <= 1'b1;
                rxrdy_q  <= 1'b1;
                open_q   <= 1'b0;
            end
            if (wr_ctrl) fcnt_q <= bus_wdata[CNT_HI:CNT_LO];
        end
    end

    // status, interrupt and read path
    logic [31:0] stat;
    logic [2:0]  masked;
    always_comb begin
        stat     = '0;
        stat[0]  = txdone_q;
        stat[1]  = rxrdy_q;
        stat[2]  = ovf_q;
        stat[4]  = rx_full;
        stat[5]  = (rx_cnt == depth_q - 1'b1);
        stat[6]  = (rx_cnt == '0);
        stat[7]  = (rx_cnt == CW'(1));
        stat[8]  = tx_full;
        stat[9]  = (tx_cnt == depth_q - 1'b1);
        stat[10] = (tx_cnt == '0);
        stat[11] = (tx_cnt == CW'(1));
        stat[12] = open_q;
        stat[13] = cs_n_q;
        stat[14] = sh_busy;
    end

    assign masked   = raw_q & {ctrl_q[CB_IE_OVF], ctrl_q[CB_IE_RX], ctrl_q[CB_IE_TX]};
    assign irq      = |masked;
    assign spi_cs_n = cs_n_q;

    always_comb begin
        unique case (bus_addr)
            RA_CTRL:   bus_rdata = ctrl_q;
            RA_FSIZE:  bus_rdata = 32'(fsize_q);
            RA_STAT:   bus_rdata = stat;
            RA_RXD:    bus_rdata = rx_dout;
            RA_CLKDIV: bus_rdata = 32'(div_q);
            RA_SSEL:   bus_rdata = 32'(ssel_q);
            RA_MASKED: bus_rdata = 32'(masked);
            RA_RAW:    bus_rdata = 32'(raw_q);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_grp_chk.sv
module spi_grp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       busy,
    input logic       en,
    input logic [4:0] fsize,
    input logic       txdone,
    input logic [2:0] raw
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);                                              // R3
    AST_CS_LOW_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cs_n);                                               // R5
    AST_NO_DONE_MID_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !txdone);                                             // R6
    AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txdone) |-> cs_n);                                       // R6
    AST_DONE_RAISES_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txdone) |-> raw[0]);                                     // R6
    AST_FSIZE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(fsize));                         // R9
endmodule

bind spi_grp_master spi_grp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .busy(sh_busy),
    .en(ctrl_q[0]), .fsize(fsize_q), .txdone(txdone_q), .raw(raw_q)
);

// File: tb/spi_grp_master_bench.sv
`timescale 1ns/1ps
module spi_grp_master_bench;
    localparam logic [3:0] A_CTRL = 4'd0, A_FSIZE = 4'd1, A_STAT = 4'd2, A_ICLR = 4'd3,
                           A_RXD = 4'd4, A_TXD = 4'd5, A_DIV = 4'd6, A_MASK = 4'd8, A_RAW = 4'd9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq, spi_sclk, spi_mosi, spi_cs_n;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    spi_grp_master u_spi_grp_master (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    // free-running observers
    int cyc = 0, sclk_rises = 0, cs_rises = 0, last_per = 0, prev_rise = 0;
    logic [31:0] mosi_cap = '0;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge spi_sclk) begin
        sclk_rises <= sclk_rises + 1;
        mosi_cap   <= {mosi_cap[30:0], spi_mosi};
        last_per   <= cyc - prev_rise;
        prev_rise  <= cyc;
    end
    always @(posedge spi_cs_n) cs_rises <= cs_rises + 1;

    // {size, tx word, expected rx word}
    localparam int NV = 7;
    localparam logic [68:0] VEC [NV] = '{
        {5'd4,  32'h0000000A, 32'h0000000A},
        {5'd8,  32'h000001A5, 32'h000000A5},
        {5'd16, 32'hDEADBEEF, 32'h0000BEEF},
        {5'd1,  32'h00000003, 32'h00000001},
        {5'd12, 32'h00012C35, 32'h00000C35},
        {5'd31, 32'hFFFFFFFF, 32'h7FFFFFFF},
        {5'd0,  32'h12345678, 32'h12345678}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 3000; k++) begin
            bus_rd(A_STAT, s);
            if (s[0]) break;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog all requirements: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] r, r0;
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(A_CTRL, r);  check("R1 control reset", r, 32'h80000102);
        bus_rd(A_FSIZE, r); check("R1 frame size reset", r, 32'd4);
        bus_rd(A_DIV, r);   check("R1 divider reset", r, 32'd7);
        bus_rd(A_STAT, r);  check("R1 status reset", r, 32'h2440);
        bus_rd(A_RAW, r);   check("R1 raw reset", r, 32'd0);
        bus_rd(A_MASK, r);  check("R1 masked reset", r, 32'd0);
        check("R1 cs_n and irq reset", {30'd0, spi_cs_n, irq}, 32'h2);

        // R2 vector table: width, order, loopback capture
        for (int i = 0; i < NV; i++) begin
            logic [4:0]  sz;
            logic [31:0] tx, ex, msk;
            int w;
            {sz, tx, ex} = VEC[i];
            w   = (sz == 0) ? 32 : int'(sz);
            msk = (w == 32) ? 32'hFFFFFFFF : ((32'h1 << w) - 32'h1);
            bus_wr(A_CTRL, 32'h2);
            bus_wr(A_FSIZE, {27'd0, sz});
            bus_wr(A_DIV, 32'd0);
            bus_wr(A_CTRL, 32'h0000_0103);
            snap = sclk_rises;
            bus_wr(A_TXD, tx);
            wait_done();
            bus_rd(A_RXD, r);
            check($sformatf("R2 rx word vector %0d", i), r, ex);
            check($sformatf("R2 mosi MSB-first vector %0d", i), mosi_cap & msk, ex);
            check($sformatf("R2 sclk edges vector %0d", i), sclk_rises - snap, w);
        end

        // R13 active / select while shifting (slow divider), R3 period
        bus_wr(A_CTRL, 32'h2);
        bus_wr(A_FSIZE, 32'd8);
        bus_wr(A_DIV, 32'd7);
        bus_wr(A_CTRL, 32'h0000_0103);
        bus_wr(A_TXD, 32'h5A);
        repeat (3) @(negedge clk);
        bus_rd(A_STAT, r);
        check("R13 active high, select low mid-frame", (r >> 12) & 32'h7, 32'h5);
        wait_done();
        bus_rd(A_RXD, r);   check("R2 rx at slow divider", r, 32'h5A);
        check("R3 sclk period divider 7", last_per, 16);
        bus_wr(A_DIV, 32'd2);
        bus_wr(A_TXD, 32'h33);
        wait_done();
        bus_rd(A_RXD, r);
        check("R3 sclk period divider 2", last_per, 6);
        check("R3 sclk idle low", {31'd0, spi_sclk}, 32'd0);
        bus_wr(A_DIV, 32'd0);

        // R4 disabled queue holds
        bus_wr(A_CTRL, 32'h2);
        bus_wr(A_FSIZE, 32'd4);
        bus_wr(A_CTRL, 32'h0000_0102);
        snap = sclk_rises;
        bus_wr(A_TXD, 32'h9);
        repeat (60) @(negedge clk);
        check("R4 no sclk while disabled", sclk_rises - snap, 0);
        bus_rd(A_STAT, r);
        check("R4 tx queued, near-empty R11", (r >> 10) & 32'h3, 32'h2);
        bus_wr(A_CTRL, 32'h0000_0103);
        wait_done();
        bus_rd(A_RXD, r);   check("R4 queued word sent on enable", r, 32'h9);

        // R5 R6 hold group of 3, R8 masked tx-done
        bus_wr(A_CTRL, 32'h0400_0323);
        snap = cs_rises;
        bus_wr(A_TXD, 32'h1);
        repeat (40) @(negedge clk);
        bus_rd(A_STAT, r);
        check("R6 no done after 1 of 3 frames", r & 32'h3, 32'h0);
        check("R5 cs held low between frames", {31'd0, spi_cs_n}, 32'd0);
        check("R13 group open flag", (r >> 12) & 32'h1, 32'h1);
        bus_wr(A_TXD, 32'h2);
        bus_wr(A_TXD, 32'h3);
        wait_done();
        repeat (2) @(negedge clk);
        check("R5 one cs rise for held group", cs_rises - snap, 1);
        bus_rd(A_RAW, r);   check("R6 raw done bits", r, 32'h3);
        bus_rd(A_MASK, r);  check("R8 masked tx-done only", r, 32'h1);
        check("R8 irq high", {31'd0, irq}, 32'd1);
        bus_rd(A_RXD, r);   check("R5 rx frame 1", r, 32'h1);
        bus_rd(A_RXD, r);   check("R5 rx frame 2", r, 32'h2);
        bus_rd(A_RXD, r);   check("R5 rx frame 3", r, 32'h3);
        bus_wr(A_ICLR, 32'h3);
        bus_rd(A_RAW, r);   check("R8 interrupt clear", r, 32'h0);
        check("R8 irq low after clear", {31'd0, irq}, 32'd0);

        // R5 pulse mode group of 3
        bus_wr(A_CTRL, 32'h0000_0303);
        snap = cs_rises;
        bus_wr(A_TXD, 32'h4);
        bus_wr(A_TXD, 32'h5);
        bus_wr(A_TXD, 32'h6);
        wait_done();
        repeat (2) @(negedge clk);
        check("R5 cs rises per frame without hold", cs_rises - snap, 3);
        for (int k = 0; k < 3; k++) bus_rd(A_RXD, r);

        // R9 frame size locked while enabled; R10 read-only registers
        bus_wr(A_FSIZE, 32'd9);
        bus_rd(A_FSIZE, r); check("R9 size write ignored when enabled", r, 32'd4);
        bus_rd(A_STAT, r0);
        bus_wr(A_STAT, 32'hFFFFFFFF);
        bus_rd(A_STAT, r);  check("R10 status write ignored", r, r0);
        bus_rd(A_RAW, r0);
        bus_wr(A_RAW, 32'h0);
        bus_rd(A_RAW, r);   check("R10 raw write ignored", r, r0);
        bus_wr(A_MASK, 32'hFFFFFFFF);
        bus_rd(A_MASK, r);  check("R10 masked write ignored", r, 32'h0);

        // R7 overflow, R8 mask mapping
        bus_wr(A_CTRL, 32'h8000_0000);
        bus_wr(A_DIV, 32'd0);
        bus_wr(A_CTRL, 32'h0000_0153);
        for (int k = 1; k <= 5; k++) begin
            bus_wr(A_TXD, k);
            wait_done();
        end
        bus_rd(A_STAT, r);
        check("R7 overflow and rx full flags", r & 32'h14, 32'h14);
        bus_rd(A_RAW, r);   check("R7 raw overflow", r, 32'h7);
        bus_rd(A_MASK, r);  check("R8 masked overflow+rx", r, 32'h6);
        bus_wr(A_ICLR, 32'h4);
        bus_rd(A_RAW, r);   check("R8 clear overflow only", r, 32'h3);
        bus_rd(A_RXD, r);   check("R7 first word kept", r, 32'h1);
        bus_rd(A_STAT, r);  check("R7 rx read clears overflow", r & 32'h4, 32'h0);

        // R12 soft reset with data pending
        bus_wr(A_CTRL, 32'h8000_0000);
        bus_rd(A_STAT, r);  check("R12 status after soft reset", r, 32'h2440);
        bus_rd(A_CTRL, r);  check("R12 control after soft reset", r, 32'h80000102);
        bus_rd(A_RAW, r);   check("R12 raw after soft reset", r, 32'h0);

        // R11 fifo depths
        bus_wr(A_CTRL, 32'h2);
        for (int k = 0; k < 3; k++) bus_wr(A_TXD, k);
        bus_rd(A_STAT, r);  check("R11 depth 4 near-full", r & 32'h300, 32'h200);
        bus_wr(A_TXD, 32'h7);
        bus_rd(A_STAT, r);  check("R11 depth 4 full", r & 32'h100, 32'h100);
        bus_wr(A_CTRL, 32'h8000_0000);
        bus_wr(A_FSIZE, 32'd8);
        bus_wr(A_CTRL, 32'h2000_0002);
        for (int k = 0; k < 31; k++) bus_wr(A_TXD, k);
        bus_rd(A_STAT, r);  check("R11 depth 32 near-full", r & 32'h300, 32'h200);
        bus_wr(A_TXD, 32'h7);
        bus_rd(A_STAT, r);  check("R11 depth 32 full", r & 32'h100, 32'h100);
        bus_wr(A_CTRL, 32'h8000_0000);
        bus_wr(A_FSIZE, 32'd20);
        bus_wr(A_CTRL, 32'h2000_0002);
        for (int k = 0; k < 8; k++) bus_wr(A_TXD, k);
        bus_rd(A_STAT, r);  check("R11 depth 8 full for wide frames", r & 32'h100, 32'h100);
        bus_wr(A_CTRL, 32'h8000_0000);
        bus_rd(A_FSIZE, r); check("R12 frame size after soft reset", r, 32'd4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule